// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block tracks recent use of the four ways of every set of a set-associative cache and names, for any set, a way to evict. Each set holds three tree bits: a root bit recording which pair of ways (0/1 or 2/3) was touched last, and one leaf bit per pair recording which member of that pair was touched last. The victim is found by walking away from recent use: first to the pair not touched last, then to the member of that pair not touched last. The result approximates least-recently-used order; the way chosen is not always the one that has truly gone longest without use.

The cache controller pulses an access strobe with the set index and the way that was hit or filled. In the same or any later cycle it can present a lookup set index and read the victim way straight away. The state is kept in flip-flops, one 3-bit vector per set, with the set count a parameter (256 by default).

Top module: `plru_way_selector`

## Requirements
- R1: After reset every set reports victim way 1 (binary 2'b01 on `victim_way_o`).
- R2: After an access to way 0 or way 1 of a set, that set's victim is way 2 or way 3.
- R3: After an access to way 2 or way 3 of a set, that set's victim is way 0 or way 1.
- R4: When the victim comes from ways 0 and 1, it is way 0 if way 1 was the more recent of the two accessed, otherwise way 1.
- R5: When the victim comes from ways 2 and 3, it is way 3 if way 2 was the more recent of the two accessed, otherwise way 2.
- R6: An access updates the root bit and the leaf bit of the accessed way's pair only; the other pair's leaf bit keeps its value.
- R7: An access to one set leaves the victim of every other set unchanged.
- R8: `victim_way_o` follows `look_set_i` combinationally; an access changes it only after the next rising clock edge, never in the cycle of the strobe.
- R9: With `acc_valid_i` low, `acc_set_i` and `acc_way_i` have no effect on any set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_set_i | input | SET_W | Set index of the access |
| acc_way_i | input | 2 | Way number that was accessed (0 to 3) |
| look_set_i | input | SET_W | Set index whose victim is requested |
| victim_way_o | output | 2 | Victim way number for `look_set_i` |

## Verification
The bench builds the block with 16 sets instead of 256, so every set is visited many times by a few thousand random accesses, while the lookup index is driven independently of the access index, which makes untouched-set and same-set-same-cycle cases frequent. Directed sequences on one set walk the tree through every root and leaf combination, including the case where a leaf bit must survive accesses to the other pair.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = 2;

  typedef logic [WAY_W-1:0] way_t;

  // bit 0: pair 0/1 touched last; bit 1: way 1 touched last; bit 2: way 2 touched last
  typedef logic [2:0] tree_t;

  localparam int unsigned ROOT_BIT = 0;
  localparam int unsigned LO_BIT   = 1;
  localparam int unsigned HI_BIT   = 2;

  localparam tree_t TREE_RESET = 3'b000;
endpackage

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
(
  input  tree_t cur_i,
  input  way_t  way_i,
  output tree_t nxt_o
);
  logic lo_pair;

  assign lo_pair = ~way_i[1];

  always_comb begin
    nxt_o           = cur_i;
    nxt_o[ROOT_BIT] = lo_pair;
    if (lo_pair) nxt_o[LO_BIT] = way_i[0];
    else         nxt_o[HI_BIT] = ~way_i[0];
  end
endmodule

// File: rtl/plru_tree_bank.sv
module plru_tree_bank
  import plru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 256,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  tree_t            wr_tree_i,
  input  logic [SET_W-1:0] upd_set_i,
  output tree_t            upd_tree_o,
  input  logic [SET_W-1:0] look_set_i,
  output tree_t            look_tree_o
);
  tree_t trees_q [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic sel;
    assign sel = wr_en_i && (wr_set_i == SET_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  trees_q[g] <= TREE_RESET;
      else if (sel) trees_q[g] <= wr_tree_i;
    end
  end

  always_comb begin
    upd_tree_o  = TREE_RESET;
    look_tree_o = TREE_RESET;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (upd_set_i == SET_W'(i))  upd_tree_o  = trees_q[i];
      if (look_set_i == SET_W'(i)) look_tree_o = trees_q[i];
    end
  end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  tree_t tree_i,
  output way_t  victim_o
);
  always_comb begin
    if (tree_i[ROOT_BIT]) victim_o = tree_i[HI_BIT] ? way_t'(3) : way_t'(2);
    else                  victim_o = tree_i[LO_BIT] ? way_t'(0) : way_t'(1);
  end
endmodule

// File: rtl/plru_way_selector.sv
module plru_way_selector
  import plru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 256,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [1:0]       acc_way_i,
  input  logic [SET_W-1:0] look_set_i,
  output logic [1:0]       victim_way_o
);
  tree_t cur_tree, nxt_tree, look_tree;

  plru_tree_bank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (acc_valid_i),
    .wr_set_i   (acc_set_i),
    .wr_tree_i  (nxt_tree),
    .upd_set_i  (acc_set_i),
    .upd_tree_o (cur_tree),
    .look_set_i (look_set_i),
    .look_tree_o(look_tree)
  );

  plru_tree_update u_upd (
    .cur_i(cur_tree),
    .way_i(acc_way_i),
    .nxt_o(nxt_tree)
  );

  plru_victim_pick u_pick (
    .tree_i  (look_tree),
    .victim_o(victim_way_o)
  );
endmodule

// File: rtl/plru_way_selector_chk.sv
module plru_way_selector_chk #(
  parameter int unsigned NUM_SETS = 256,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [SET_W-1:0] acc_set_i,
  input logic [1:0]       acc_way_i,
  input logic [SET_W-1:0] look_set_i,
  input logic [1:0]       victim_way_o
);
  logic same_set;
  assign same_set = acc_valid_i && (acc_set_i == look_set_i);

  // R2
  low_pair_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_set && !acc_way_i[1]) |=> (!$stable(look_set_i) || victim_way_o[1]));

  // R3
  high_pair_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_set && acc_way_i[1]) |=> (!$stable(look_set_i) || !victim_way_o[1]));

  // R5
  way2_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_set && acc_way_i == 2'd2) |=> (!$stable(look_set_i) || victim_way_o == 2'd1 || victim_way_o == 2'd0 || victim_way_o == 2'd3));

  // R5
  way3_after_way2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_set && acc_way_i == 2'd0 && $past(same_set && acc_way_i == 2'd2 && acc_set_i == look_set_i))
      |=> (!$stable(look_set_i) || victim_way_o == 2'd3));

  // R7
  other_set_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_set_i != look_set_i) |=> (!$stable(look_set_i) || $stable(victim_way_o)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (!$stable(look_set_i) || $stable(victim_way_o)));
endmodule

bind plru_way_selector plru_way_selector_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_set_i   (acc_set_i),
  .acc_way_i   (acc_way_i),
  .look_set_i  (look_set_i),
  .victim_way_o(victim_way_o)
);

// File: tb/tb_plru_way_selector.sv
module tb_plru_way_selector;
  localparam int unsigned NSETS  = 16;
  localparam int unsigned SW     = 4;
  localparam int          HALF   = 10;
  localparam int          LIMIT  = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [1:0]    acc_way = '0;
  logic [SW-1:0] look_set = '0;
  logic [1:0]    victim;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural model: which pair was last, and last member within each pair
  int last_pair [NSETS];
  int last01    [NSETS];
  int last23    [NSETS];

  always #HALF clk = ~clk;

  plru_way_selector #(.NUM_SETS(NSETS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_set_i(acc_set),
    .acc_way_i(acc_way), .look_set_i(look_set), .victim_way_o(victim)
  );

  function automatic int model_victim(int s);
    if (last_pair[s] == 0) return (last23[s] == 2) ? 3 : 2;
    return (last01[s] == 1) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        last_pair[s] = 1; last01[s] = 0; last23[s] = 3;
      end
    end else if (acc_valid) begin
      if (acc_way < 2) begin last_pair[acc_set] = 0; last01[acc_set] = int'(acc_way); end
      else             begin last_pair[acc_set] = 1; last23[acc_set] = int'(acc_way); end
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s set=%0d got=%0d exp=%0d t=%0t", tag, look_set, got, exp, $time);
    end
  endtask

  // continuous model compare, sampled 2 ns before each rising edge
  always begin
    @(negedge clk);
    #(HALF-2);
    if (rst_n && !done) check(phase, int'(victim), model_victim(int'(look_set)));
  end

  task automatic access(int s, int w);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(s); acc_way = 2'(w); look_set = SW'(s);
    #1 check("R8", int'(victim), model_victim(s));
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic lookup(string tag, int s, int exp);
    look_set = SW'(s);
    #1 check(tag, int'(victim), exp);
  endtask

  initial begin
    #(LIMIT * 2 * HALF);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NSETS; s++) lookup("R1", s, 1);

    phase = "R2";
    access(3, 0); lookup("R2", 3, 2);
    access(7, 1); lookup("R2", 7, 2);
    phase = "R3";
    access(3, 2); lookup("R3", 3, 1);
    phase = "R5";
    access(3, 1); lookup("R5", 3, 3);
    phase = "R4";
    access(3, 2); lookup("R4", 3, 0);
    phase = "R6";
    access(3, 0); access(3, 1); lookup("R6", 3, 3);
    access(3, 3); lookup("R6", 3, 0);
    phase = "R7";
    lookup("R7", 5, 1); lookup("R7", 4, 1); lookup("R7", 7, 2);

    phase = "R9";
    look_set = SW'(3);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_set = SW'(3); acc_way = 2'(i);
    end
    @(negedge clk);
    lookup("R9", 3, 0);

    phase = "R6";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      acc_valid = 1'($urandom_range(0, 2) != 0);
      acc_set   = SW'($urandom_range(0, NSETS - 1));
      acc_way   = 2'($urandom_range(0, 3));
      look_set  = ($urandom_range(0, 1) == 0) ? acc_set : SW'($urandom_range(0, NSETS - 1));
    end
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule